// File: doc/BRIEF.md
# Half to Single Precision Widener

This block turns a 16-bit IEEE 754 half-precision word into the 32-bit single-precision word of the same value. The half word is placed in the upper part of a 32-bit word. A single formula then produces the result for every input class: normal numbers, subnormals, signed zeros, infinities and NaNs. The formula uses a renormalization shift taken from a leading-zero count, a mask that forces the exponent field to all ones, and a mask that clears the magnitude when it is zero. No decoder selects a case.

Every half value can be written exactly as a single value, so the widening needs no rounding. An input strobe travels with the data. A parameter places an optional register on the output. In the default build that register is present, so a result appears one clock after its input and stays until the next strobed input.

Top module: `half_single_widen`

## Requirements
- R1: With the output register enabled (the default), `res_valid` equals `src_valid` delayed by exactly one clock cycle.
- R2: While `rst_n` is low, `res_valid` is 0 and `res_word` is 0x00000000.
- R3: A cycle with `src_valid` low leaves `res_word` unchanged in the following cycle, whatever `src_half` carries.
- R4: Bit 31 of the result equals bit 15 of the input for every one of the 65536 input codes.
- R5: An input with exponent field e in bits 14:10 between 1 and 30 and fraction f in bits 9:0 gives exponent field e+112 in bits 30:23 and fraction f<<13 in bits 22:0.
- R6: A subnormal input (e = 0, f ≠ 0) whose highest set fraction bit is at index p gives exponent field 103+p, with the fraction bits below p moved to the top of bits 22:0 and zeros below them.
- R7: An input with bits 14:0 all zero gives bits 30:0 all zero, and the sign is kept.
- R8: An input with e = 31 and f = 0 gives 0x7F800000 or 0xFF800000, depending on the sign.
- R9: An input with e = 31 and f ≠ 0 gives exponent field 255 and fraction f<<13. The payload is kept and no bit is forced.
- R10: 0x0618→0x38C30000, 0x000F→0x35700000, 0x0000→0x00000000, 0x8000→0x80000000, 0x7C00→0x7F800000, 0xFC00→0xFF800000 and 0x7CFF→0x7F9FE000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Marks `src_half` as holding a value to convert |
| src_half | input | 16 | Half-precision operand |
| res_valid | output | 1 | Marks `res_word` as a fresh result |
| res_word | output | 32 | Single-precision result |

## Verification
The bench sweeps all 65536 input codes against a reference that decodes the fields. The riskiest codes are the subnormals. A wrong threshold on the leading-zero count, or a wrong shift width, shifts their exponent by one or more steps, or drops the leading one into the fraction field. The signed zeros are checked because a zero mask that fails to fire gives a tiny nonzero value, or loses the sign. Exponent-31 codes are checked because an infinity mask carried at the wrong bit leaves NaNs with a finite exponent or alters their payload. The strobe tests confirm that the result holds during idle cycles and appears exactly one cycle after its input.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   // output staging variant selected by the top-level parameter
   typedef enum logic {
      HSW_COMB = 1'b0,
      HSW_REG  = 1'b1
   } stage_mode_e;

   localparam int unsigned HSW_HALF_W  = 16;
   localparam int unsigned HSW_HALF_E  = 5;
   localparam int unsigned HSW_SINGLE_W = 32;
   localparam int unsigned HSW_SINGLE_E = 8;
endpackage

// File: rtl/hsw_lzc.sv
// Binary-search leading-zero counter: halving steps, then an all-zero correction.
module hsw_lzc #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned LW = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   output logic [LW:0]      count
);
   if ((1 << LW) != WIDTH) begin : g_bad_width
      $error("hsw_lzc: WIDTH must be a power of two");
   end

   logic [WIDTH-1:0] xs [0:LW];
   logic [LW:0]      cs [0:LW];

   assign xs[0] = din;
   assign cs[0] = '0;

   for (genvar k = 0; k < LW; k++) begin : g_step
      localparam int unsigned STEP = 1 << (LW - 1 - k);
      logic empty_top;
      assign empty_top = ~|xs[k][WIDTH-1 -: STEP];
      assign xs[k+1]   = empty_top ? (xs[k] << STEP) : xs[k];
      assign cs[k+1]   = cs[k] + (empty_top ? (LW+1)'(STEP) : '0);
   end

   assign count = cs[LW] + {{LW{1'b0}}, ~|xs[LW]};
endmodule

// File: rtl/hsw_core.sv
// Branch-free widening datapath.
module hsw_core #(
   parameter int unsigned HW = 16,
   parameter int unsigned HE = 5,
   parameter int unsigned SW = 32,
   parameter int unsigned SE = 8,
   localparam int unsigned LW    = $clog2(SW),
   localparam int unsigned SM    = SW - 1 - SE,
   localparam int unsigned RSH   = SE - HE,
   localparam int unsigned BDIFF = ((1 << (SE - 1)) - 1) - ((1 << (HE - 1)) - 1)
) (
   input  logic [HW-1:0] half_in,
   output logic [SW-1:0] single_out
);
   localparam logic [SW-1:0] SIGN_BIT = SW'(1) << (SW - 1);
   localparam logic [SW-1:0] MAG_MASK = ~SIGN_BIT;
   localparam logic [SW-1:0] OVF_ADD  = SW'(1) << (SW - 1 - HE);
   localparam logic [SW-1:0] EXP_MASK = ((SW'(1) << SE) - SW'(1)) << SM;

   logic [SW-1:0]        placed, sgn, mag;
   logic [LW:0]          lead;
   logic [LW:0]          renorm;
   logic signed [SW-1:0] ovf_sum, zero_src;
   logic [SW-1:0]        special_m, zero_m;
   logic [SW-1:0]        aligned, exp_adj, body;

   assign placed = {half_in, (SW-HW)'(0)};
   assign sgn    = placed & SIGN_BIT;
   assign mag    = placed & MAG_MASK;

   hsw_lzc #(.WIDTH(SW)) u_lzc (
      .din   (mag),
      .count (lead)
   );

   // shift only when the count runs past the exponent field (subnormal or zero)
   assign renorm = (lead > (LW+1)'(HE)) ? (lead - (LW+1)'(HE)) : '0;

   // exponent all ones carries into the field above after the add
   assign ovf_sum   = $signed(mag + OVF_ADD);
   assign special_m = SW'(ovf_sum >>> SE) & EXP_MASK;

   // all ones only for a zero magnitude
   assign zero_src = $signed(mag - SW'(1));
   assign zero_m   = SW'(zero_src >>> (SW - 1));

   assign aligned = (mag << renorm) >> RSH;
   assign exp_adj = (SW'(BDIFF) - SW'(renorm)) << SM;
   assign body    = ((aligned + exp_adj) | special_m) & ~zero_m;

   assign single_out = sgn | body;
endmodule

// File: rtl/hsw_stage.sv
// Optional output register: a pass-through or a flop with a load enable.
module hsw_stage #(
   parameter bit          REGISTERED = 1'b1,
   parameter int unsigned W          = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   output logic         v_out,
   output logic [W-1:0] d_out
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_out <= 1'b0;
            d_out <= '0;
         end else begin
            v_out <= v_in;
            if (v_in) d_out <= d_in;
         end
      end
   end else begin : g_wire
      assign v_out = v_in;
      assign d_out = d_in;
   end
endmodule

// File: rtl/half_single_widen.sv
module half_single_widen #(
   parameter int unsigned HALF_W   = hsw_pkg::HSW_HALF_W,
   parameter int unsigned HALF_E   = hsw_pkg::HSW_HALF_E,
   parameter int unsigned SINGLE_W = hsw_pkg::HSW_SINGLE_W,
   parameter int unsigned SINGLE_E = hsw_pkg::HSW_SINGLE_E,
   parameter hsw_pkg::stage_mode_e STAGE = hsw_pkg::HSW_REG
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                src_valid,
   input  logic [HALF_W-1:0]   src_half,
   output logic                res_valid,
   output logic [SINGLE_W-1:0] res_word
);
   localparam int unsigned HALF_M   = HALF_W - 1 - HALF_E;
   localparam int unsigned SINGLE_M = SINGLE_W - 1 - SINGLE_E;

   if (SINGLE_E <= HALF_E) begin : g_bad_exp
      $error("half_single_widen: single exponent must be wider");
   end
   if (SINGLE_M < HALF_M + (SINGLE_W - HALF_W) - (SINGLE_E - HALF_E) - (SINGLE_W - HALF_W)) begin : g_bad_man
      $error("half_single_widen: single fraction too narrow");
   end
   if (SINGLE_W <= HALF_W) begin : g_bad_w
      $error("half_single_widen: output must be wider than input");
   end

   logic [SINGLE_W-1:0] conv;

   hsw_core #(
      .HW (HALF_W),
      .HE (HALF_E),
      .SW (SINGLE_W),
      .SE (SINGLE_E)
   ) u_core (
      .half_in    (src_half),
      .single_out (conv)
   );

   hsw_stage #(
      .REGISTERED (STAGE == hsw_pkg::HSW_REG),
      .W          (SINGLE_W)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (src_valid),
      .d_in  (conv),
      .v_out (res_valid),
      .d_out (res_word)
   );
endmodule

// File: rtl/hsw_chk.sv
module hsw_chk #(
   parameter int unsigned HW  = 16,
   parameter int unsigned HE  = 5,
   parameter int unsigned SW  = 32,
   parameter int unsigned SE  = 8,
   parameter bit          REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          src_valid,
   input logic [HW-1:0] src_half,
   input logic          res_valid,
   input logic [SW-1:0] res_word
);
   localparam int unsigned HM = HW - 1 - HE;
   localparam int unsigned SM = SW - 1 - SE;
   localparam int unsigned BD = ((1 << (SE - 1)) - 1) - ((1 << (HE - 1)) - 1);

   logic [HW-1:0] held;
   logic          seen;

   if (REG) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held <= '0;
            seen <= 1'b0;
         end else begin
            seen <= 1'b1;
            if (src_valid) held <= src_half;
         end
      end

      p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
         seen |-> (res_valid == $past(src_valid)));
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (seen && !src_valid) |=> $stable(res_word));
   end else begin : g_pass
      assign held = src_half;
      assign seen = 1'b1;
   end

   logic [HE-1:0] h_exp;
   logic [HM-1:0] h_man;
   assign h_exp = held[HW-2 -: HE];
   assign h_man = held[HM-1:0];

   p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_word[SW-1] == held[HW-1]));
   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && held[HW-2:0] == '0) |-> (res_word[SW-2:0] == '0));
   p_special_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (&h_exp)) |-> (&res_word[SW-2 -: SE]));
   p_nan_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (&h_exp)) |-> (res_word[SM-1 -: HM] == h_man));
   p_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && h_exp != '0 && !(&h_exp)) |->
         (res_word[SW-2 -: SE] == SE'(h_exp) + SE'(BD) && res_word[SM-1 -: HM] == h_man));
endmodule

bind half_single_widen hsw_chk #(
   .HW  (HALF_W),
   .HE  (HALF_E),
   .SW  (SINGLE_W),
   .SE  (SINGLE_E),
   .REG (STAGE == hsw_pkg::HSW_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_half  (src_half),
   .res_valid (res_valid),
   .res_word  (res_word)
);

// File: tb/half_single_widen_test.sv
module half_single_widen_test;
   localparam time CLK_P = 5ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_valid = 1'b0;
   logic [15:0] src_half = '0;
   logic        res_valid;
   logic [31:0] res_word;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   half_single_widen uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_half  (src_half),
      .res_valid (res_valid),
      .res_word  (res_word)
   );

   function automatic logic [31:0] model(input logic [15:0] h);
      logic       s;
      logic [4:0] e;
      logic [9:0] f;
      int         p;
      logic [22:0] fr;
      s = h[15]; e = h[14:10]; f = h[9:0];
      if (e == 5'd0 && f == 10'd0) return {s, 31'd0};
      if (e == 5'd31) return {s, 8'hFF, f, 13'd0};
      if (e != 5'd0) return {s, 8'(e) + 8'd112, f, 13'd0};
      p = 0;
      for (int i = 0; i < 10; i++) if (f[i]) p = i;
      fr = 23'(f) << (23 - p);
      return {s, 8'(103 + p), fr};
   endfunction

   function automatic string class_tag(input logic [15:0] h);
      if (h[14:0] == 15'd0) return "R7";
      if (h[14:10] == 5'd31) return (h[9:0] == 10'd0) ? "R8" : "R9";
      if (h[14:10] == 5'd0) return "R6";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // R2: output state while reset is held
   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R2 valid", 32'(res_valid), 32'd0);
      check("R2 word", res_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 after release", 32'(res_valid), 32'd0);
   endtask

   // single strobed conversion, result sampled one cycle later
   task automatic convert(input logic [15:0] h, output logic [31:0] r);
      @(negedge clk);
      src_valid = 1'b1; src_half = h;
      @(negedge clk);
      src_valid = 1'b0;
      r = res_word;
   endtask

   task automatic t_vectors();
      logic [15:0] ins [7] = '{16'h0618, 16'h000F, 16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7CFF};
      logic [31:0] outs[7] = '{32'h38C30000, 32'h35700000, 32'h00000000, 32'h80000000,
                               32'h7F800000, 32'hFF800000, 32'h7F9FE000};
      logic [31:0] r;
      for (int i = 0; i < 7; i++) begin
         convert(ins[i], r);
         check("R10 vector", r, outs[i]);
      end
   endtask

   // R1: one-cycle latency of the strobe
   task automatic t_latency();
      @(negedge clk);
      src_valid = 1'b1; src_half = 16'h3C00;
      check("R1 same cycle", 32'(res_valid), 32'd0);
      @(negedge clk);
      src_valid = 1'b0;
      check("R1 next cycle valid", 32'(res_valid), 32'd1);
      check("R1 next cycle data", res_word, 32'h3F800000);
      @(negedge clk);
      check("R1 drops", 32'(res_valid), 32'd0);
   endtask

   // R3: idle cycles with changing data leave the result unchanged
   task automatic t_hold();
      logic [31:0] r;
      convert(16'hC500, r);
      check("R3 loaded", r, 32'hC0A00000);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         src_valid = 1'b0; src_half = 16'(16'h1234 + i * 16'h1111);
         @(negedge clk);
         check("R3 held", res_word, 32'hC0A00000);
      end
   endtask

   // R4..R9: every code streamed back to back
   task automatic t_sweep();
      logic [15:0] prev;
      @(negedge clk);
      src_valid = 1'b1; src_half = 16'h0000; prev = 16'h0000;
      for (int v = 1; v <= 65536; v++) begin
         @(negedge clk);
         check(class_tag(prev), res_word, model(prev));
         check("R4 sign", 32'(res_word[31]), 32'(prev[15]));
         if (v < 65536) begin
            src_half = 16'(v); prev = 16'(v);
         end else begin
            src_valid = 1'b0;
         end
      end
   endtask

   initial begin
      t_reset();
      t_latency();
      t_vectors();
      t_hold();
      t_sweep();
      finish_run();
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule